// File: doc/BRIEF.md
# Consumed Frame Validator

This block sits behind the deserializer of a serial fieldbus node and decides whether a received consumed-data frame can be accepted. Upstream logic captures the control byte, the PDU-type byte and the length byte, and keeps a running byte index. The deserializer raises one of two single-cycle end-of-frame pulses. One pulse means the CRC and the end sequence were good. The other means the CRC was wrong.

When the good pulse arrives, the block checks four things. The variable-type match flag must be high. The control byte must carry the response-data code. The PDU byte must carry the produced/consumed code. The byte index must equal the length byte plus a fixed offset. If all four hold, the block emits a one-cycle frame-ok pulse. A frame that fails any check is dropped without a trace on the pulse output. This covers an identification frame that arrives where response data was expected: its control code differs, so it is discarded.

The length check runs on either end-of-frame pulse, and its result does not depend on the CRC outcome. The sticky length-error flag therefore signals a wrong length and nothing else. A one-cycle clear input, driven by a status read, resets it.

Top module: `consumed_frame_validator`

## Requirements
- R1: While reset is asserted, and after it is released, frame_ok_p_o and len_err_o are low until an end-of-frame pulse is seen.
- R2: eof_good_p_i is high for one cycle with var_match_i=1, ctrl_byte_i=0x02, pdu_byte_i=0x40 and byte_idx_i equal to len_byte_i+5. In that case frame_ok_p_o is high for exactly the following cycle.
- R3: With var_match_i=0 at the good pulse, frame_ok_p_o stays low.
- R4: With ctrl_byte_i other than 0x02 at the good pulse (for example the identification code 0x03), frame_ok_p_o stays low.
- R5: With pdu_byte_i other than 0x40 at the good pulse, frame_ok_p_o stays low.
- R6: With byte_idx_i different from len_byte_i+5 at the good pulse, frame_ok_p_o stays low and len_err_o goes high in the next cycle.
- R7: The length is also checked on eof_crc_bad_p_i. A mismatch sets len_err_o. A match leaves it low. frame_ok_p_o never rises after a CRC-bad pulse, even when it coincides with the good pulse.
- R8: len_err_o stays high until a cycle with stat_clr_i=1 and no length mismatch, and it reads low in the following cycle. A mismatch in the same cycle as stat_clr_i keeps it high.
- R9: Header, length and index inputs that change while no end-of-frame pulse is high have no effect on either output.
- R10: The sum len_byte_i+5 is formed without wrap-around. len_byte_i=0xFE therefore never matches byte_idx_i=0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_byte_i | input | BYTE_W | Captured control byte |
| pdu_byte_i | input | BYTE_W | Captured PDU-type byte |
| len_byte_i | input | BYTE_W | Captured length byte |
| byte_idx_i | input | IDX_W | Running byte index of the frame |
| var_match_i | input | 1 | Variable type matches the addressed variable |
| eof_good_p_i | input | 1 | End of frame with good CRC and end sequence |
| eof_crc_bad_p_i | input | 1 | End of frame with wrong CRC |
| stat_clr_i | input | 1 | Status read, clears the length error |
| frame_ok_p_o | output | 1 | One-cycle frame accepted pulse |
| len_err_o | output | 1 | Sticky length error status |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit index, an offset of 5, control code 0x02 and PDU code 0x40. With an index as wide as the length byte, the sum of length and offset can pass 255. This brings within reach a wrapped index value that a truncating comparator would wrongly accept. The fixed codes let the bench present the identification control code next to the response-data code and show that the first is rejected.

// File: rtl/cfv_pkg.sv
package cfv_pkg;
  localparam int unsigned DEF_BYTE_W  = 8;
  localparam int unsigned DEF_IDX_W   = 8;
  localparam int unsigned DEF_LEN_OFS = 5;
  localparam logic [7:0]  DEF_CTRL_RSP = 8'h02;
  localparam logic [7:0]  DEF_PDU_PC   = 8'h40;

  typedef struct packed {
    logic hdr_ok;
    logic len_ok;
  } chk_t;
endpackage

// File: rtl/cfv_hdr_match.sv
module cfv_hdr_match #(
  parameter int unsigned      BYTE_W   = cfv_pkg::DEF_BYTE_W,
  parameter logic [BYTE_W-1:0] CTRL_CODE = BYTE_W'(cfv_pkg::DEF_CTRL_RSP),
  parameter logic [BYTE_W-1:0] PDU_CODE  = BYTE_W'(cfv_pkg::DEF_PDU_PC)
) (
  input  logic [BYTE_W-1:0] ctrl_i,
  input  logic [BYTE_W-1:0] pdu_i,
  input  logic              var_match_i,
  output logic              hdr_ok_o
);
  logic ctrl_hit, pdu_hit;
  assign ctrl_hit = (ctrl_i == CTRL_CODE);
  assign pdu_hit  = (pdu_i == PDU_CODE);
  assign hdr_ok_o = ctrl_hit & pdu_hit & var_match_i;
endmodule

// File: rtl/cfv_len_check.sv
module cfv_len_check #(
  parameter int unsigned BYTE_W  = cfv_pkg::DEF_BYTE_W,
  parameter int unsigned IDX_W   = cfv_pkg::DEF_IDX_W,
  parameter int unsigned LEN_OFS = cfv_pkg::DEF_LEN_OFS
) (
  input  logic [BYTE_W-1:0] len_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              len_ok_o
);
  localparam int unsigned MAX_W = (IDX_W > BYTE_W) ? IDX_W : BYTE_W;
  localparam int unsigned SUM_W = MAX_W + 1;

  logic [SUM_W-1:0] exp_idx, idx_ext;
  // widened so the offset cannot wrap (R10)
  assign exp_idx  = SUM_W'(len_i) + SUM_W'(LEN_OFS);
  assign idx_ext  = SUM_W'(idx_i);
  assign len_ok_o = (exp_idx == idx_ext);
endmodule

// File: rtl/cfv_status.sv
module cfv_status (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eof_good_p_i,
  input  logic          eof_crc_bad_p_i,
  input  logic          stat_clr_i,
  input  cfv_pkg::chk_t chk_i,
  output logic          frame_ok_p_o,
  output logic          len_err_o
);
  logic eof_any, ok_d, err_d;
  logic ok_q, err_q;

  assign eof_any = eof_good_p_i | eof_crc_bad_p_i;
  assign ok_d    = eof_good_p_i & ~eof_crc_bad_p_i & chk_i.hdr_ok & chk_i.len_ok;

  always_comb begin
    err_d = err_q;
    if (eof_any && !chk_i.len_ok) err_d = 1'b1;
    else if (stat_clr_i)          err_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      err_q <= err_d;
    end
  end

  assign frame_ok_p_o = ok_q;
  assign len_err_o    = err_q;

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_err_o && !stat_clr_i) |=> len_err_o); // R8
endmodule

// File: rtl/consumed_frame_validator.sv
module consumed_frame_validator #(
  parameter int unsigned       BYTE_W    = cfv_pkg::DEF_BYTE_W,
  parameter int unsigned       IDX_W     = cfv_pkg::DEF_IDX_W,
  parameter int unsigned       LEN_OFS   = cfv_pkg::DEF_LEN_OFS,
  parameter logic [BYTE_W-1:0] CTRL_CODE = BYTE_W'(cfv_pkg::DEF_CTRL_RSP),
  parameter logic [BYTE_W-1:0] PDU_CODE  = BYTE_W'(cfv_pkg::DEF_PDU_PC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] ctrl_byte_i,
  input  logic [BYTE_W-1:0] pdu_byte_i,
  input  logic [BYTE_W-1:0] len_byte_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic              var_match_i,
  input  logic              eof_good_p_i,
  input  logic              eof_crc_bad_p_i,
  input  logic              stat_clr_i,
  output logic              frame_ok_p_o,
  output logic              len_err_o
);
  cfv_pkg::chk_t chk;

  cfv_hdr_match #(.BYTE_W(BYTE_W), .CTRL_CODE(CTRL_CODE), .PDU_CODE(PDU_CODE)) u_hdr (
    .ctrl_i      (ctrl_byte_i),
    .pdu_i       (pdu_byte_i),
    .var_match_i (var_match_i),
    .hdr_ok_o    (chk.hdr_ok)
  );

  cfv_len_check #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .LEN_OFS(LEN_OFS)) u_len (
    .len_i    (len_byte_i),
    .idx_i    (byte_idx_i),
    .len_ok_o (chk.len_ok)
  );

  cfv_status u_stat (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .eof_good_p_i    (eof_good_p_i),
    .eof_crc_bad_p_i (eof_crc_bad_p_i),
    .stat_clr_i      (stat_clr_i),
    .chk_i           (chk),
    .frame_ok_p_o    (frame_ok_p_o),
    .len_err_o       (len_err_o)
  );

  AST_OK_AFTER_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eof_good_p_i |=> !frame_ok_p_o); // R9
  AST_BAD_CRC_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_crc_bad_p_i |=> !frame_ok_p_o); // R7
  AST_NO_MATCH_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !var_match_i |=> !frame_ok_p_o); // R3
  AST_CTRL_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_byte_i != CTRL_CODE) |=> !frame_ok_p_o); // R4
  AST_PDU_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdu_byte_i != PDU_CODE) |=> !frame_ok_p_o); // R5
  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !eof_good_p_i && !eof_crc_bad_p_i) |=> !len_err_o); // R8
  AST_ERR_RISE_AT_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!len_err_o && !eof_good_p_i && !eof_crc_bad_p_i) |=> !len_err_o); // R9
endmodule

// File: tb/consumed_frame_validator_bench.sv
module consumed_frame_validator_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ctrl, pdu, len, idx;
  logic       vm, good, bad, clr;
  logic       ok, err;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  consumed_frame_validator u_consumed_frame_validator (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_byte_i(ctrl), .pdu_byte_i(pdu),
    .len_byte_i(len), .byte_idx_i(idx), .var_match_i(vm),
    .eof_good_p_i(good), .eof_crc_bad_p_i(bad), .stat_clr_i(clr),
    .frame_ok_p_o(ok), .len_err_o(err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_hdr(input logic [7:0] c, input logic [7:0] p,
                         input logic [7:0] l, input logic [7:0] i, input logic m);
    ctrl = c; pdu = p; len = l; idx = i; vm = m;
  endtask

  // drive one end-of-frame cycle, return at the negedge after the capturing edge
  task automatic eof(input logic g, input logic b, input logic c);
    @(negedge clk);
    good = g; bad = b; clr = c;
    @(negedge clk);
    good = 1'b0; bad = 1'b0; clr = 1'b0;
  endtask

  task automatic clear_status();
    eof(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 ok in reset", ok, 1'b0);
    chk("R1 err in reset", err, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ok after reset", ok, 1'b0);
    chk("R1 err after reset", err, 1'b0);
  endtask

  task automatic t_good();
    set_hdr(8'h02, 8'h40, 8'd10, 8'd15, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R2 ok pulse", ok, 1'b1);
    chk("R2 no len err", err, 1'b0);
    @(negedge clk);
    chk("R2 ok single cycle", ok, 1'b0);
  endtask

  task automatic t_no_match();
    set_hdr(8'h02, 8'h40, 8'd10, 8'd15, 1'b0);
    eof(1'b1, 1'b0, 1'b0);
    chk("R3 no ok without var match", ok, 1'b0);
  endtask

  task automatic t_ctrl();
    set_hdr(8'h03, 8'h40, 8'd10, 8'd15, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R4 id ctrl rejected", ok, 1'b0);
    set_hdr(8'h03, 8'h40, 8'd10, 8'd15, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R4 second id ctrl rejected", ok, 1'b0);
    set_hdr(8'h00, 8'h40, 8'd10, 8'd15, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R4 ctrl 0x00 rejected", ok, 1'b0);
  endtask

  task automatic t_pdu();
    set_hdr(8'h02, 8'h41, 8'd10, 8'd15, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R5 pdu rejected", ok, 1'b0);
  endtask

  task automatic t_len_good();
    set_hdr(8'h02, 8'h40, 8'd10, 8'd14, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R6 short frame no ok", ok, 1'b0);
    chk("R6 len err set", err, 1'b1);
    clear_status();
    chk("R8 cleared", err, 1'b0);
  endtask

  task automatic t_len_crc();
    set_hdr(8'h02, 8'h40, 8'd20, 8'd24, 1'b1);
    eof(1'b0, 1'b1, 1'b0);
    chk("R7 len err on crc bad", err, 1'b1);
    chk("R7 no ok on crc bad", ok, 1'b0);
    clear_status();
    set_hdr(8'h02, 8'h40, 8'd20, 8'd25, 1'b1);
    eof(1'b0, 1'b1, 1'b0);
    chk("R7 matching len no err on crc bad", err, 1'b0);
    chk("R7 no ok on crc bad, all match", ok, 1'b0);
    eof(1'b1, 1'b1, 1'b0);
    chk("R7 no ok when both pulses", ok, 1'b0);
  endtask

  task automatic t_sticky();
    set_hdr(8'h02, 8'h40, 8'd4, 8'd3, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    set_hdr(8'h02, 8'h40, 8'd4, 8'd9, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", err, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R8 err held across good frame", err, 1'b1);
    set_hdr(8'h02, 8'h40, 8'd4, 8'd0, 1'b1);
    eof(1'b0, 1'b1, 1'b1);
    chk("R8 set wins over clear", err, 1'b1);
    clear_status();
    chk("R8 clear after", err, 1'b0);
  endtask

  task automatic t_idle_ignore();
    set_hdr(8'h02, 8'h40, 8'd1, 8'd6, 1'b1);
    @(negedge clk);
    set_hdr(8'h07, 8'h00, 8'd50, 8'd0, 1'b0);
    @(negedge clk);
    chk("R9 no ok without eof", ok, 1'b0);
    chk("R9 no err without eof", err, 1'b0);
  endtask

  task automatic t_wrap();
    set_hdr(8'h02, 8'h40, 8'hFE, 8'h03, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R10 wrapped index rejected", ok, 1'b0);
    chk("R10 wrapped index len err", err, 1'b1);
    clear_status();
    set_hdr(8'h02, 8'h40, 8'hFA, 8'hFF, 1'b1);
    eof(1'b1, 1'b0, 1'b0);
    chk("R10 max index accepted", ok, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; good = 1'b0; bad = 1'b0; clr = 1'b0;
    set_hdr(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    t_reset();
    t_good();
    t_no_match();
    t_ctrl();
    t_pdu();
    t_len_good();
    t_len_crc();
    t_sticky();
    t_idle_ignore();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule